// File: doc/BRIEF.md
# Priority-Threshold Interrupt Preemption Filter

This block decides, every cycle, whether one of its pending interrupt sources may break into the code that is running. Each source has an 8-bit urgency value, where 0 is the most urgent and 255 the least. Each source also has a pending bit, which a pulse sets. The block selects the most urgent pending source. It compares that source with an effective threshold built from three values: a software-written priority floor, a one-bit global silence mask, and the priority of the context now executing.

Both software values are reached through a small write/read register port. The running priority comes from a short stack of active levels. When the core accepts an offered source, that source's level is pushed onto the stack. When a handler finishes, a return pulse pops the stack. A source that loses the comparison keeps its pending bit. It is checked again on every cycle and is offered as soon as the threshold allows it. Vector fetch, context stacking and tail-chaining are left to the surrounding logic.

Top module: `irq_preempt_filter`

## Requirements
- R1: After reset the floor and mask read 0, no source is pending, no request is raised, `run_prio` is 256 and `stack_ovf` is 0.
- R2: With `reg_sel`=0 the register port writes and reads the 8-bit floor. With `reg_sel`=1 it writes and reads the mask in bit 0, and the upper read bits are 0. `reg_rdata` shows the selected register at once, and a write is visible from the cycle after the write edge.
- R3: A `pend_set` bit sets that source's pending bit on the next edge. The bit stays set until that source is accepted, and `preempt_id` always names a pending source.
- R4: Among pending sources the winner has the smallest priority value. When several share that value, the lowest index wins.
- R5: The threshold is `run_prio` when the floor is 0. Otherwise it is the smaller of the floor and `run_prio`. A request is raised only when the winner's value is strictly below the threshold. An equal or larger value is held.
- R6: While the mask is 1, no request is raised, whatever the floor, the running level or the pending sources.
- R7: With no active handler, `run_prio` is 256, so any pending source can be offered when the floor and the mask allow it.
- R8: `accept` while a request is raised clears the winner's pending bit. From the next cycle, the winner's priority is the new `run_prio`.
- R9: `ret_strobe` pops one level. A pop on an empty stack is ignored. When `accept` is taken in the same cycle, the push is done and the return is dropped.
- R10: An accept when the stack holds DEPTH levels still clears the pending bit, but `run_prio` does not change. The accept sets `stack_ovf`, which stays set until reset.
- R11: A held source is raised in the cycle after a floor or mask write relaxes the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-flop synchronizer |
| pend_set | input | N_SRC | One pulse per source sets its pending bit |
| src_prio | input | N_SRC*PRIO_W | Per-source priority, source i in bits [i*PRIO_W +: PRIO_W] |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the floor, 1 selects the mask |
| reg_wdata | input | PRIO_W | Write data |
| reg_rdata | output | PRIO_W | Read data of the selected register |
| accept | input | 1 | Core takes the offered source |
| ret_strobe | input | 1 | Handler return, pops one level |
| preempt_req | output | 1 | Winner beats the threshold |
| preempt_id | output | $clog2(N_SRC) | Index of the winning source |
| pending | output | N_SRC | Pending bits |
| run_prio | output | PRIO_W+1 | Running priority, 256 when no handler is active |
| stack_ovf | output | 1 | Sticky overflow of the active stack |

## Verification
`preempt_req` and `preempt_id` come through combinational logic from registered state. They therefore follow a pending pulse, a register write or an accept one edge later. `pending`, `run_prio` and `stack_ovf` update on the edge that takes the strobe. `reg_rdata` follows `reg_sel` with no delay. The bench drives each stimulus just after a rising edge and samples one time unit after the next rising edge. It also checks after each deassertion of reset, once the synchronizer has released the internal reset.

// File: rtl/irq_pf_pkg.sv
package irq_pf_pkg;
  typedef enum logic {
    SEL_FLOOR = 1'b0,
    SEL_MASK  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_pf_regs.sv
module irq_pf_regs
  import irq_pf_pkg::*;
#(
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  reg_sel_e          sel,
  input  logic [PRIO_W-1:0] wdata,
  output logic [PRIO_W-1:0] floor_q,
  output logic              mask_q,
  output logic [PRIO_W-1:0] rdata
);
  logic [PRIO_W-1:0] floor_d;
  logic              mask_d;

  always_comb begin
    floor_d = floor_q;
    mask_d  = mask_q;
    if (we) begin
      case (sel)
        SEL_FLOOR: floor_d = wdata;
        SEL_MASK:  mask_d  = wdata[0];
        default:   floor_d = floor_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      floor_q <= '0;
      mask_q  <= 1'b0;
    end else if (we) begin
      floor_q <= floor_d;
      mask_q  <= mask_d;
    end
  end

  assign rdata = (sel == SEL_MASK) ? {{(PRIO_W-1){1'b0}}, mask_q} : floor_q;
endmodule

// File: rtl/irq_pf_arbiter.sv
module irq_pf_arbiter #(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 8,
  localparam int IDW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]        pend,
  input  logic [N_SRC*PRIO_W-1:0] prio_flat,
  output logic                    any,
  output logic [IDW-1:0]          win_id,
  output logic [PRIO_W-1:0]       win_prio
);
  always_comb begin
    any      = 1'b0;
    win_id   = '0;
    win_prio = '1;
    for (int i = 0; i < N_SRC; i++) begin
      if (pend[i] && (!any || (prio_flat[i*PRIO_W +: PRIO_W] < win_prio))) begin
        any      = 1'b1;
        win_id   = IDW'(i);
        win_prio = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irq_pf_stack.sv
module irq_pf_stack #(
  parameter int PRIO_W = 8,
  parameter int DEPTH  = 4,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [PRIO_W-1:0] push_val,
  output logic [PRIO_W:0]   run_prio,
  output logic              ovf
);
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              ovf_d;
  logic [PRIO_W-1:0] mem [DEPTH];
  logic [PRIO_W-1:0] top_val;
  logic              full;

  assign full = (cnt_q == CW'(DEPTH));

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf;
    if (push) begin
      if (full) ovf_d = 1'b1;
      else      cnt_d = cnt_q + 1'b1;
    end else if (pop && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf   <= ovf_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && (cnt_q == CW'(g))) mem[g] <= push_val;
    end
  end

  always_comb begin
    top_val = '1;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_q == CW'(i + 1)) top_val = mem[i];
    end
  end

  assign run_prio = (cnt_q == '0) ? {1'b1, {PRIO_W{1'b0}}} : {1'b0, top_val};
endmodule

// File: rtl/irq_preempt_filter.sv
module irq_preempt_filter
  import irq_pf_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 8,
  parameter int DEPTH  = 4,
  localparam int IDW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SRC-1:0]        pend_set,
  input  logic [N_SRC*PRIO_W-1:0] src_prio,
  input  logic                    reg_we,
  input  logic                    reg_sel,
  input  logic [PRIO_W-1:0]       reg_wdata,
  output logic [PRIO_W-1:0]       reg_rdata,
  input  logic                    accept,
  input  logic                    ret_strobe,
  output logic                    preempt_req,
  output logic [IDW-1:0]          preempt_id,
  output logic [N_SRC-1:0]        pending,
  output logic [PRIO_W:0]         run_prio,
  output logic                    stack_ovf
);
  logic [1:0]        rst_sync;
  logic              rst_sync_n;
  logic [PRIO_W-1:0] floor_q;
  logic              mask_q;
  logic              any;
  logic [PRIO_W-1:0] win_prio;
  logic [PRIO_W:0]   floor_ext, thr;
  logic              take;
  logic [N_SRC-1:0]  pend_q, pend_d, clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  irq_pf_regs #(.PRIO_W(PRIO_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .we(reg_we), .sel(reg_sel_e'(reg_sel)),
    .wdata(reg_wdata), .floor_q(floor_q), .mask_q(mask_q), .rdata(reg_rdata)
  );

  irq_pf_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
    .pend(pend_q), .prio_flat(src_prio), .any(any),
    .win_id(preempt_id), .win_prio(win_prio)
  );

  // Floor of zero means no filtering; otherwise the more urgent bound wins.
  assign floor_ext   = {1'b0, floor_q};
  assign thr         = (floor_q == '0) ? run_prio
                     : ((floor_ext < run_prio) ? floor_ext : run_prio);
  assign preempt_req = any && !mask_q && ({1'b0, win_prio} < thr);
  assign take        = accept && preempt_req;

  always_comb begin
    clr = '0;
    if (take) clr[preempt_id] = 1'b1;
    pend_d = (pend_q & ~clr) | pend_set;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pend_q <= '0;
    else             pend_q <= pend_d;
  end
  assign pending = pend_q;

  irq_pf_stack #(.PRIO_W(PRIO_W), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_sync_n), .push(take), .pop(ret_strobe && !take),
    .push_val(win_prio), .run_prio(run_prio), .ovf(stack_ovf)
  );
endmodule

// File: rtl/irq_pf_checker.sv
module irq_pf_checker #(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 8,
  localparam int IDW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    preempt_req,
  input logic [IDW-1:0]          preempt_id,
  input logic [N_SRC-1:0]        pending,
  input logic [N_SRC*PRIO_W-1:0] src_prio,
  input logic [PRIO_W-1:0]       floor_q,
  input logic                    mask_q,
  input logic [PRIO_W:0]         run_prio,
  input logic                    stack_ovf,
  input logic                    accept,
  input logic                    ret_strobe
);
  logic [PRIO_W-1:0] offered;
  assign offered = src_prio[preempt_id*PRIO_W +: PRIO_W];

  assert_mask_silences_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |-> !preempt_req);

  assert_beats_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
    preempt_req |-> ({1'b0, offered} < run_prio));

  assert_beats_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (preempt_req && (floor_q != '0)) |-> (offered < floor_q));

  assert_offer_is_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    preempt_req |-> pending[preempt_id]);

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stack_ovf |=> stack_ovf);

  assert_idle_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_prio[PRIO_W] && ret_strobe && !accept) |=> run_prio[PRIO_W]);
endmodule

bind irq_preempt_filter irq_pf_checker #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .preempt_req(preempt_req), .preempt_id(preempt_id),
  .pending(pending), .src_prio(src_prio), .floor_q(floor_q), .mask_q(mask_q),
  .run_prio(run_prio), .stack_ovf(stack_ovf), .accept(accept), .ret_strobe(ret_strobe)
);

// File: tb/test_irq_preempt_filter.sv
`timescale 1ns/1ps
module test_irq_preempt_filter;
  localparam int N = 8;
  localparam int W = 8;
  localparam int D = 4;

  logic           clk;
  logic           rst_n;
  logic [N-1:0]   pend_set;
  logic [N*W-1:0] src_prio;
  logic [W-1:0]   prio_tb [N];
  logic           reg_we, reg_sel;
  logic [W-1:0]   reg_wdata, reg_rdata;
  logic           accept, ret_strobe;
  logic           preempt_req;
  logic [2:0]     preempt_id;
  logic [N-1:0]   pending;
  logic [W:0]     run_prio;
  logic           stack_ovf;
  int             checks, errors;
  bit             done;

  irq_preempt_filter #(.N_SRC(N), .PRIO_W(W), .DEPTH(D)) i_irq_preempt_filter (
    .clk(clk), .rst_n(rst_n), .pend_set(pend_set), .src_prio(src_prio),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .accept(accept), .ret_strobe(ret_strobe), .preempt_req(preempt_req),
    .preempt_id(preempt_id), .pending(pending), .run_prio(run_prio), .stack_ovf(stack_ovf)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) src_prio[i*W +: W] = prio_tb[i];
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic sel, input logic [W-1:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic pend(input int idx);
    pend_set[idx] = 1'b1;
    tick();
    pend_set = '0;
  endtask

  task automatic acc();
    accept = 1'b1; tick(); accept = 1'b0;
  endtask

  task automatic ret();
    ret_strobe = 1'b1; tick(); ret_strobe = 1'b0;
  endtask

  task automatic t_reset();
    reg_sel = 1'b0; #1;
    check("R1 floor", reg_rdata, 0);
    reg_sel = 1'b1; #1;
    check("R1 mask", reg_rdata, 0);
    check("R1 req", preempt_req, 0);
    check("R1 pending", pending, 0);
    check("R7 run_prio idle", run_prio, 256);
    check("R1 ovf", stack_ovf, 0);
  endtask

  task automatic t_regs();
    wr(1'b0, 8'h40);
    reg_sel = 1'b0; #1;
    check("R2 floor readback", reg_rdata, 8'h40);
    wr(1'b1, 8'hFF);
    check("R2 mask readback bit0 only", reg_rdata, 1);
    reg_sel = 1'b0; #1;
    check("R2 floor kept", reg_rdata, 8'h40);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h00);
    check("R2 floor cleared", reg_rdata, 0);
  endtask

  task automatic t_arb();
    prio_tb[1] = 8'd10; prio_tb[3] = 8'd20; prio_tb[5] = 8'd10;
    pend(3);
    check("R3 pending set", pending, 8'h08);
    check("R7 idle any source req", preempt_req, 1);
    check("R4 single id", preempt_id, 3);
    pend_set = 8'h22; tick(); pend_set = '0;
    check("R4 tie lowest index", preempt_id, 1);
    check("R3 pending set", pending, 8'h2A);
  endtask

  task automatic t_mask();
    wr(1'b1, 8'h01);
    check("R6 mask blocks", preempt_req, 0);
    check("R3 held pending", pending, 8'h2A);
    wr(1'b1, 8'h00);
    check("R11 unmask fires", preempt_req, 1);
    check("R11 unmask id", preempt_id, 1);
  endtask

  task automatic t_floor();
    wr(1'b0, 8'd10);
    check("R5 equal to floor held", preempt_req, 0);
    wr(1'b0, 8'd11);
    check("R11 floor relax fires", preempt_req, 1);
    check("R5 floor id", preempt_id, 1);
    wr(1'b0, 8'd0);
  endtask

  task automatic t_nest();
    acc();
    check("R8 pending cleared", pending, 8'h28);
    check("R8 run_prio pushed", run_prio, 10);
    check("R5 equal running held", preempt_req, 0);
    prio_tb[0] = 8'd5;
    pend(0);
    check("R5 more urgent nests", preempt_req, 1);
    check("R4 nested id", preempt_id, 0);
    acc();
    check("R8 run_prio nested", run_prio, 5);
    ret();
    check("R9 pop to previous", run_prio, 10);
    check("R5 still held", preempt_req, 0);
    ret();
    check("R9 pop to idle", run_prio, 256);
    check("R4 next winner", preempt_id, 5);
    check("R7 idle offers", preempt_req, 1);
    acc();
    check("R8 pending cleared 2", pending, 8'h08);
    ret();
    acc();
    check("R8 run_prio 20", run_prio, 20);
    prio_tb[2] = 8'd17;
    wr(1'b0, 8'd15);
    pend(2);
    check("R5 floor more restrictive", preempt_req, 0);
    wr(1'b0, 8'd0);
    check("R11 floor zero fires", preempt_req, 1);
    check("R5 id under running", preempt_id, 2);
    acc(); ret(); ret();
    check("R9 back to idle", run_prio, 256);
    check("R3 all drained", pending, 0);
  endtask

  task automatic t_ovf();
    prio_tb[0] = 8'd200; prio_tb[1] = 8'd150; prio_tb[2] = 8'd100;
    prio_tb[3] = 8'd50;  prio_tb[4] = 8'd10;
    for (int i = 0; i < 4; i++) begin
      pend(i);
      acc();
    end
    check("R8 four levels", run_prio, 50);
    check("R10 no ovf yet", stack_ovf, 0);
    pend(4);
    check("R10 offer when full", preempt_id, 4);
    acc();
    check("R10 ovf set", stack_ovf, 1);
    check("R10 run_prio unchanged", run_prio, 50);
    check("R10 pending cleared", pending, 0);
    for (int i = 0; i < 4; i++) ret();
    check("R9 drained", run_prio, 256);
    ret();
    check("R9 empty pop ignored", run_prio, 256);
    check("R10 ovf sticky", stack_ovf, 1);
  endtask

  task automatic t_same();
    pend(0);
    accept = 1'b1; ret_strobe = 1'b1; tick();
    accept = 1'b0; ret_strobe = 1'b0;
    check("R9 push beats return", run_prio, 200);
    ret();
    check("R9 pop after", run_prio, 256);
  endtask

  initial begin
    #150000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; pend_set = '0; reg_we = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    accept = 1'b0; ret_strobe = 1'b0;
    for (int i = 0; i < N; i++) prio_tb[i] = 8'hFF;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) tick();
    t_reset();
    t_regs();
    t_arb();
    t_mask();
    t_floor();
    t_nest();
    t_ovf();
    t_same();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule